// File: doc/BRIEF.md
# RISC instruction field decoder

The block takes one 32-bit instruction word of a load/store RISC instruction set with three encodings (register, immediate and jump) and turns it into everything the execute stage needs. It returns the two source register numbers, the destination register, the shift amount, a 32-bit immediate, an ALU operation code and a set of strobes: register write, memory read, memory write, branch, branch-on-not-equal, jump and use-immediate. An illegal flag marks words outside the supported set.

The decoder is purely combinational. It sits between instruction fetch and the register file and ALU. The ALU, register file and PC logic are not part of it. A control module reads the opcode and function code and produces a small struct of strobes. A datapath module uses that struct to slice the fields, extend the immediate and pick the destination.

Top module: `risc_field_decoder`

## Requirements
- R1: For every instruction, srcA = instr[25:21], srcB = instr[20:16] and shamt = instr[10:6].
- R2: With opcode 0, the function codes 32 (add), 34 (sub), 36 (and), 37 (or), 38 (xor), 39 (nor) and 42 (set-less-than) produce aluOp 0, 1, 2, 3, 4, 5 and 6. These decodes also give dest = instr[15:11], regWrite = 1, useImm = 0 and imm = 0.
- R3: With opcode 0, the function codes 0, 2 and 3 select shift left logical (aluOp 7), shift right logical (aluOp 8) and shift right arithmetic (aluOp 9). The shift amount comes from shamt, and dest = rd.
- R4: Opcode 35 (load word) gives memRead = 1, regWrite = 1, dest = instr[20:16], aluOp 0, useImm = 1 and imm = the sign-extended instr[15:0].
- R5: Opcode 43 (store word) gives memWrite = 1, aluOp 0, useImm = 1 and a sign-extended imm. It gives regWrite = 0 and memRead = 0.
- R6: Opcodes 8 (add immediate, aluOp 0) and 10 (set-less-than immediate, aluOp 6) sign-extend the immediate, write dest = rt and give useImm = 1.
- R7: Opcodes 12, 13 and 14 (and, or and xor immediate; aluOp 2, 3 and 4) zero-extend the immediate and write dest = rt.
- R8: Opcode 15 (load upper immediate) gives imm = {instr[15:0], 16'h0000}, aluOp 10 (pass the second operand), regWrite = 1 and dest = rt.
- R9: Opcodes 4 (branch if equal) and 5 (branch if not equal) give branch = 1, aluOp 1, a sign-extended word-offset imm and no register or memory write. branchNe is 1 only for opcode 5.
- R10: Opcodes 2 (jump) and 3 (jump and link) give jump = 1 and imm = the zero-extended instr[25:0]. Jump and link also gives regWrite = 1 with dest = 31, and plain jump writes nothing.
- R11: A write whose destination would be register 0 gives regWrite = 0. The other outputs are the same as for any other destination.
- R12: Any other opcode, or opcode 0 with any other function code, gives illegal = 1. It also gives regWrite, memRead, memWrite, branch and jump all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| srcA | output | 5 | First source register number |
| srcB | output | 5 | Second source register number |
| dest | output | 5 | Destination register number (0 when nothing is written) |
| shamt | output | 5 | Shift amount |
| imm | output | 32 | Extended immediate |
| aluOp | output | 4 | ALU operation code |
| useImm | output | 1 | ALU second operand comes from imm |
| regWrite | output | 1 | Register file write strobe |
| memRead | output | 1 | Data memory read strobe |
| memWrite | output | 1 | Data memory write strobe |
| branch | output | 1 | Conditional branch |
| branchNe | output | 1 | Branch condition is not-equal |
| jump | output | 1 | Unconditional jump |
| illegal | output | 1 | Unsupported instruction |

## Verification
Every supported opcode and function code is applied with field values that have distinct bit patterns. This shows that each field is sliced from the correct bits and that every code reaches its own ALU operation. Each immediate class is tried with an immediate whose bit 15 is set and then with one whose bit 15 is clear, which separates sign extension, zero extension and upper placement. Destination register 0 is used on writing instructions to show that the write is suppressed. Unused opcodes and unused function codes show that the illegal flag comes with all strobes low.

// File: rtl/dec_pkg.sv
package dec_pkg;
  parameter int XLEN  = 32;
  parameter int REG_W = 5;
  parameter int OP_W  = 6;
  parameter int FN_W  = 6;
  parameter int IMM_W = 16;
  parameter int JT_W  = 26;
  parameter int ALU_W = 4;
  localparam logic [REG_W-1:0] LINK_REG = '1;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'd0,  OP_J    = 6'd2,  OP_JAL  = 6'd3;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'd4,  OP_BNE  = 6'd5,  OP_ADDI = 6'd8;
  localparam logic [OP_W-1:0] OP_SLTI  = 6'd10, OP_ANDI = 6'd12, OP_ORI  = 6'd13;
  localparam logic [OP_W-1:0] OP_XORI  = 6'd14, OP_LUI  = 6'd15, OP_LW   = 6'd35;
  localparam logic [OP_W-1:0] OP_SW    = 6'd43;

  localparam logic [FN_W-1:0] FN_SLL = 6'd0,  FN_SRL = 6'd2,  FN_SRA = 6'd3;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32, FN_SUB = 6'd34, FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37, FN_XOR = 6'd38, FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR  = 4'd3,
    ALU_XOR = 4'd4, ALU_NOR = 4'd5, ALU_SLT = 4'd6, ALU_SLL = 4'd7,
    ALU_SRL = 4'd8, ALU_SRA = 4'd9, ALU_PASS = 4'd10
  } aluOp_e;

  typedef enum logic [2:0] {IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_UPPER, IMM_JUMP} immKind_e;
  typedef enum logic [1:0] {DST_NONE, DST_RD, DST_RT, DST_LINK} dstKind_e;

  typedef struct packed {
    logic     wantWrite;
    logic     memRead;
    logic     memWrite;
    logic     branch;
    logic     branchNe;
    logic     jump;
    logic     useImm;
    logic     illegal;
    immKind_e immKind;
    dstKind_e dstKind;
    aluOp_e   aluOp;
  } ctrl_t;
endpackage

// File: rtl/dec_control.sv
module dec_control
  import dec_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.aluOp   = ALU_ADD;
    ctrl.immKind = IMM_NONE;
    ctrl.dstKind = DST_NONE;
    case (opcode)
      OP_RTYPE: begin
        ctrl.wantWrite = 1'b1;
        ctrl.dstKind   = DST_RD;
        case (funct)
          FN_ADD: ctrl.aluOp = ALU_ADD;
          FN_SUB: ctrl.aluOp = ALU_SUB;
          FN_AND: ctrl.aluOp = ALU_AND;
          FN_OR:  ctrl.aluOp = ALU_OR;
          FN_XOR: ctrl.aluOp = ALU_XOR;
          FN_NOR: ctrl.aluOp = ALU_NOR;
          FN_SLT: ctrl.aluOp = ALU_SLT;
          FN_SLL: ctrl.aluOp = ALU_SLL;
          FN_SRL: ctrl.aluOp = ALU_SRL;
          FN_SRA: ctrl.aluOp = ALU_SRA;
          default: begin
            ctrl.illegal   = 1'b1;
            ctrl.wantWrite = 1'b0;
            ctrl.dstKind   = DST_NONE;
          end
        endcase
      end
      OP_ADDI, OP_SLTI: begin
        ctrl.wantWrite = 1'b1;
        ctrl.dstKind   = DST_RT;
        ctrl.useImm    = 1'b1;
        ctrl.immKind   = IMM_SEXT;
        ctrl.aluOp     = (opcode == OP_SLTI) ? ALU_SLT : ALU_ADD;
      end
      OP_ANDI, OP_ORI, OP_XORI: begin
        ctrl.wantWrite = 1'b1;
        ctrl.dstKind   = DST_RT;
        ctrl.useImm    = 1'b1;
        ctrl.immKind   = IMM_ZEXT;
        ctrl.aluOp     = (opcode == OP_ANDI) ? ALU_AND :
                         (opcode == OP_ORI)  ? ALU_OR  : ALU_XOR;
      end
      OP_LUI: begin
        ctrl.wantWrite = 1'b1;
        ctrl.dstKind   = DST_RT;
        ctrl.useImm    = 1'b1;
        ctrl.immKind   = IMM_UPPER;
        ctrl.aluOp     = ALU_PASS;
      end
      OP_LW: begin
        ctrl.wantWrite = 1'b1;
        ctrl.memRead   = 1'b1;
        ctrl.dstKind   = DST_RT;
        ctrl.useImm    = 1'b1;
        ctrl.immKind   = IMM_SEXT;
      end
      OP_SW: begin
        ctrl.memWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.immKind  = IMM_SEXT;
      end
      OP_BEQ, OP_BNE: begin
        ctrl.branch   = 1'b1;
        ctrl.branchNe = (opcode == OP_BNE);
        ctrl.immKind  = IMM_SEXT;
        ctrl.aluOp    = ALU_SUB;
      end
      OP_J, OP_JAL: begin
        ctrl.jump      = 1'b1;
        ctrl.immKind   = IMM_JUMP;
        ctrl.wantWrite = (opcode == OP_JAL);
        ctrl.dstKind   = (opcode == OP_JAL) ? DST_LINK : DST_NONE;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/dec_datapath.sv
module dec_datapath
  import dec_pkg::*;
(
  input  logic [XLEN-1:0]  instr,
  input  ctrl_t            ctrl,
  output logic [REG_W-1:0] srcA,
  output logic [REG_W-1:0] srcB,
  output logic [REG_W-1:0] dest,
  output logic [REG_W-1:0] shamt,
  output logic [XLEN-1:0]  imm,
  output logic             regWrite
);
  localparam int RS_LO = XLEN - OP_W - REG_W;
  localparam int RT_LO = RS_LO - REG_W;
  localparam int RD_LO = RT_LO - REG_W;
  localparam int SH_LO = RD_LO - REG_W;

  logic [IMM_W-1:0] imm16;
  logic [JT_W-1:0]  target;
  logic [REG_W-1:0] rdField;

  assign srcA    = instr[RS_LO +: REG_W];
  assign srcB    = instr[RT_LO +: REG_W];
  assign rdField = instr[RD_LO +: REG_W];
  assign shamt   = instr[SH_LO +: REG_W];
  assign imm16   = instr[IMM_W-1:0];
  assign target  = instr[JT_W-1:0];

  always_comb begin
    case (ctrl.immKind)
      IMM_SEXT:  imm = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
      IMM_ZEXT:  imm = {{(XLEN-IMM_W){1'b0}}, imm16};
      IMM_UPPER: imm = {imm16, {(XLEN-IMM_W){1'b0}}};
      IMM_JUMP:  imm = {{(XLEN-JT_W){1'b0}}, target};
      default:   imm = '0;
    endcase
    case (ctrl.dstKind)
      DST_RD:   dest = rdField;
      DST_RT:   dest = srcB;
      DST_LINK: dest = LINK_REG;
      default:  dest = '0;
    endcase
  end

  assign regWrite = ctrl.wantWrite && (dest != '0);
endmodule

// File: rtl/risc_field_decoder.sv
module risc_field_decoder
  import dec_pkg::*;
(
  input  logic [31:0] instr,
  output logic [4:0]  srcA,
  output logic [4:0]  srcB,
  output logic [4:0]  dest,
  output logic [4:0]  shamt,
  output logic [31:0] imm,
  output logic [3:0]  aluOp,
  output logic        useImm,
  output logic        regWrite,
  output logic        memRead,
  output logic        memWrite,
  output logic        branch,
  output logic        branchNe,
  output logic        jump,
  output logic        illegal
);
  ctrl_t ctrl;

  dec_control u_ctrl (
    .opcode(instr[XLEN-1 -: OP_W]),
    .funct (instr[FN_W-1:0]),
    .ctrl  (ctrl)
  );

  dec_datapath u_dp (
    .instr   (instr),
    .ctrl    (ctrl),
    .srcA    (srcA),
    .srcB    (srcB),
    .dest    (dest),
    .shamt   (shamt),
    .imm     (imm),
    .regWrite(regWrite)
  );

  assign aluOp    = ctrl.aluOp;
  assign useImm   = ctrl.useImm;
  assign memRead  = ctrl.memRead;
  assign memWrite = ctrl.memWrite;
  assign branch   = ctrl.branch;
  assign branchNe = ctrl.branchNe;
  assign jump     = ctrl.jump;
  assign illegal  = ctrl.illegal;

  always_comb begin
    // R12: an illegal word raises no strobe
    p_illegal_quiet_r12: assert (!illegal || !(regWrite || memRead || memWrite || branch || jump))
      else $error("illegal word raised a strobe");
    // R11: a granted write never targets register 0
    p_no_zero_dest_r11: assert (!regWrite || dest != '0)
      else $error("write to register 0");
    // R5: a store never writes the register file
    p_store_no_reg_r5: assert (!memWrite || (!regWrite && !memRead))
      else $error("store also writes or reads");
    // R8: the pass operation carries an upper immediate
    p_upper_low_zero_r8: assert (aluOp != ALU_PASS || imm[15:0] == '0)
      else $error("upper immediate has low bits");
    // R9: a branch writes nothing
    p_branch_no_write_r9: assert (!branch || (!regWrite && !memWrite && !jump))
      else $error("branch writes");
  end
endmodule

// File: tb/risc_field_decoder_test.sv
module risc_field_decoder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr;
  logic [4:0]  srcA, srcB, dest, shamt;
  logic [31:0] imm;
  logic [3:0]  aluOp;
  logic useImm, regWrite, memRead, memWrite, branch, branchNe, jump, illegal;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  risc_field_decoder uut (
    .instr(instr), .srcA(srcA), .srcB(srcB), .dest(dest), .shamt(shamt),
    .imm(imm), .aluOp(aluOp), .useImm(useImm), .regWrite(regWrite),
    .memRead(memRead), .memWrite(memWrite), .branch(branch),
    .branchNe(branchNe), .jump(jump), .illegal(illegal)
  );

  function automatic logic [31:0] rEnc(input logic [5:0] fn, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [4:0] rd,
                                       input logic [4:0] sh);
    return {6'd0, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] iEnc(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] k);
    return {op, rs, rt, k};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #2;
  endtask

  function automatic logic [7:0] strobes();
    return {useImm, regWrite, memRead, memWrite, branch, branchNe, jump, illegal};
  endfunction

  task automatic t_reset_state();
    apply(32'h0000_0000);   // sll r0,r0,0: legal, no write
    check("R11", "nop regWrite", {31'd0, regWrite}, 32'd0);
    check("R3", "nop aluOp", {28'd0, aluOp}, 32'd7);
    check("R12", "nop illegal", {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_fields();
    apply(rEnc(6'd32, 5'd17, 5'd18, 5'd8, 5'd21));
    check("R1", "srcA", {27'd0, srcA}, 32'd17);
    check("R1", "srcB", {27'd0, srcB}, 32'd18);
    check("R1", "shamt", {27'd0, shamt}, 32'd21);
    apply(iEnc(6'd35, 5'd10, 5'd5, 16'h7A3C));
    check("R1", "I srcA", {27'd0, srcA}, 32'd10);
    check("R1", "I srcB", {27'd0, srcB}, 32'd5);
  endtask

  task automatic t_rtype_alu();
    logic [5:0] fns [7] = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd38, 6'd39, 6'd42};
    for (int i = 0; i < 7; i++) begin
      apply(rEnc(fns[i], 5'd3, 5'd4, 5'd9, 5'd0));
      check("R2", "aluOp", {28'd0, aluOp}, i);
      check("R2", "dest", {27'd0, dest}, 32'd9);
      check("R2", "strobes", {24'd0, strobes()}, 32'b0100_0000);
      check("R2", "imm", imm, 32'd0);
    end
  endtask

  task automatic t_shifts();
    logic [5:0] fns [3] = '{6'd0, 6'd2, 6'd3};
    for (int i = 0; i < 3; i++) begin
      apply(rEnc(fns[i], 5'd0, 5'd16, 5'd10, 5'd8));
      check("R3", "aluOp", {28'd0, aluOp}, 7 + i);
      check("R3", "shamt", {27'd0, shamt}, 32'd8);
      check("R3", "dest", {27'd0, dest}, 32'd10);
      check("R3", "regWrite", {31'd0, regWrite}, 32'd1);
    end
  endtask

  task automatic t_load_store();
    apply(iEnc(6'd35, 5'd19, 5'd8, 16'hFFE0));
    check("R4", "lw strobes", {24'd0, strobes()}, 32'b1110_0000);
    check("R4", "lw dest", {27'd0, dest}, 32'd8);
    check("R4", "lw imm", imm, 32'hFFFF_FFE0);
    check("R4", "lw aluOp", {28'd0, aluOp}, 32'd0);
    apply(iEnc(6'd43, 5'd19, 5'd8, 16'h0030));
    check("R5", "sw strobes", {24'd0, strobes()}, 32'b1001_0000);
    check("R5", "sw imm", imm, 32'h0000_0030);
    check("R5", "sw aluOp", {28'd0, aluOp}, 32'd0);
  endtask

  task automatic t_arith_imm();
    apply(iEnc(6'd8, 5'd16, 5'd16, 16'hFFFC));
    check("R6", "addi imm", imm, 32'hFFFF_FFFC);
    check("R6", "addi aluOp", {28'd0, aluOp}, 32'd0);
    check("R6", "addi dest", {27'd0, dest}, 32'd16);
    check("R6", "addi strobes", {24'd0, strobes()}, 32'b1100_0000);
    apply(iEnc(6'd10, 5'd18, 5'd8, 16'h000A));
    check("R6", "slti imm", imm, 32'h0000_000A);
    check("R6", "slti aluOp", {28'd0, aluOp}, 32'd6);
  endtask

  task automatic t_logic_imm();
    logic [5:0] ops [3] = '{6'd12, 6'd13, 6'd14};
    for (int i = 0; i < 3; i++) begin
      apply(iEnc(ops[i], 5'd16, 5'd17, 16'h8F0F));
      check("R7", "imm", imm, 32'h0000_8F0F);
      check("R7", "aluOp", {28'd0, aluOp}, 2 + i);
      check("R7", "dest", {27'd0, dest}, 32'd17);
      check("R7", "strobes", {24'd0, strobes()}, 32'b1100_0000);
    end
  endtask

  task automatic t_upper();
    apply(iEnc(6'd15, 5'd0, 5'd8, 16'hAAAA));
    check("R8", "lui imm", imm, 32'hAAAA_0000);
    check("R8", "lui aluOp", {28'd0, aluOp}, 32'd10);
    check("R8", "lui dest", {27'd0, dest}, 32'd8);
    check("R8", "lui regWrite", {31'd0, regWrite}, 32'd1);
  endtask

  task automatic t_branches();
    apply(iEnc(6'd4, 5'd20, 5'd21, 16'hFFF8));
    check("R9", "beq strobes", {24'd0, strobes()}, 32'b0000_1000);
    check("R9", "beq imm", imm, 32'hFFFF_FFF8);
    check("R9", "beq aluOp", {28'd0, aluOp}, 32'd1);
    apply(iEnc(6'd5, 5'd8, 5'd9, 16'h0004));
    check("R9", "bne strobes", {24'd0, strobes()}, 32'b0000_1100);
    check("R9", "bne imm", imm, 32'h0000_0004);
  endtask

  task automatic t_jumps();
    apply({6'd2, 26'h3FF_0123});
    check("R10", "j strobes", {24'd0, strobes()}, 32'b0000_0010);
    check("R10", "j imm", imm, 32'h03FF_0123);
    apply({6'd3, 26'h000_4567});
    check("R10", "jal strobes", {24'd0, strobes()}, 32'b0100_0010);
    check("R10", "jal dest", {27'd0, dest}, 32'd31);
    check("R10", "jal imm", imm, 32'h0000_4567);
  endtask

  task automatic t_zero_dest();
    apply(rEnc(6'd32, 5'd1, 5'd2, 5'd0, 5'd0));
    check("R11", "add r0 regWrite", {31'd0, regWrite}, 32'd0);
    check("R11", "add r0 aluOp", {28'd0, aluOp}, 32'd0);
    apply(iEnc(6'd35, 5'd3, 5'd0, 16'h0008));
    check("R11", "lw r0 strobes", {24'd0, strobes()}, 32'b1010_0000);
    apply(iEnc(6'd15, 5'd0, 5'd0, 16'h1234));
    check("R11", "lui r0 regWrite", {31'd0, regWrite}, 32'd0);
    check("R11", "lui r0 imm", imm, 32'h1234_0000);
  endtask

  task automatic t_illegal();
    logic [5:0] ops [5] = '{6'd1, 6'd9, 6'd32, 6'd44, 6'd63};
    for (int i = 0; i < 5; i++) begin
      apply(iEnc(ops[i], 5'd4, 5'd7, 16'h1234));
      check("R12", "bad opcode strobes", {24'd0, strobes() & 8'h7F}, 32'h01);
    end
    apply(rEnc(6'd33, 5'd4, 5'd7, 5'd9, 5'd0));
    check("R12", "bad funct strobes", {24'd0, strobes() & 8'h7F}, 32'h01);
    apply(rEnc(6'd8, 5'd31, 5'd0, 5'd0, 5'd0));
    check("R12", "funct 8 strobes", {24'd0, strobes() & 8'h7F}, 32'h01);
  endtask

  initial begin
    instr = '0;
    t_reset_state();
    t_fields();
    t_rtype_alu();
    t_shifts();
    t_load_store();
    t_arith_imm();
    t_logic_imm();
    t_upper();
    t_branches();
    t_jumps();
    t_zero_dest();
    t_illegal();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule